// File: doc/BRIEF.md
# Double-Precision Floating-Point Maximum Unit

This unit takes two 64-bit IEEE 754 binary64 operands, called the first and second source, and returns the larger of the two. It also returns an invalid-operation flag. All comparisons are quiet. Positive zero ranks above negative zero. A NaN is never preferred over a number: when only one operand is a NaN, the result is the other operand. When both operands are NaNs, the result is the canonical quiet NaN.

The operands can come from one of two places: the floating-point register file or the integer register file. A single mode input selects the source. The operand pair from the other source is ignored. The result and its meaning are the same in both modes.

The result and the flag pass through one register stage by default, so they appear one clock after the operands are sampled. A parameter selects a purely combinational variant instead. The field widths are parameters and default to binary64.

Top module: `fmax_d_unit`

## Requirements
- R1: When the second source is strictly less than the first under a quiet sign-magnitude comparison, the result is the first source. Infinities, normals and subnormals all take part, and a negative value is always below a positive one.
- R2: When the first source is strictly less than the second, the result is the second source.
- R3: When both operands are zeros of opposite sign, the result is +0 (all bits zero) in either operand order. When both operands are bit-identical non-NaN values, the result is that value.
- R4: When both operands are NaNs, the result is the canonical NaN 64'h7FF8_0000_0000_0000. A NaN has exponent field bits [62:52] all ones and a nonzero fraction in bits [51:0].
- R5: When exactly one operand is a NaN, the result is the other operand, bit for bit.
- R6: The invalid flag is 1 exactly when at least one operand is a signaling NaN. A signaling NaN is a NaN with fraction bit 51 clear. Quiet NaNs (bit 51 set) and all non-NaN values leave the flag at 0.
- R7: With the mode input at 1, the integer-file operand pair is used. With the mode input at 0, the floating-point pair is used. The unselected pair has no effect on the result or the flag.
- R8: With the default registered variant, the result and flag reflect the operands present at the previous rising clock edge. While reset is low, both outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| use_int_src | input | 1 | 1 selects the integer-file operands, 0 selects the floating-point-file operands |
| fp_src1 | input | 64 | First source from the floating-point register file |
| fp_src2 | input | 64 | Second source from the floating-point register file |
| int_src1 | input | 64 | First source from the integer register file |
| int_src2 | input | 64 | Second source from the integer register file |
| max_out | output | 64 | Maximum of the selected operands |
| invalid_out | output | 1 | Invalid-operation flag |

## Verification
The bench goes after the signed-zero pair in both orders. A design that compared raw bits or used a plain signed compare would return -0 for one of the two orders. It also exercises quiet and signaling NaNs of both signs in each operand position. A design that let a NaN win would echo the NaN instead of the number, and one that skipped canonicalisation would leak a payload when both operands are NaNs. Quiet NaNs must leave the flag clear, which exposes a flag raised for every NaN. Subnormals, infinities and negative pairs test the magnitude ordering that a reversed negative-side compare would get wrong. Garbage on the unselected source pair catches a mode mux that is inverted or stuck.

// File: rtl/fmax_pkg.sv
package fmax_pkg;
   // Per-operand classification produced by fmax_classify
   typedef struct packed {
      logic sign;
      logic is_nan;
      logic is_snan;
      logic is_zero;
   } fp_class_t;
endpackage

// File: rtl/fmax_classify.sv
module fmax_classify
   import fmax_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] op,
   output fp_class_t             cls
);
   localparam int W = 1 + EXP_W + FRAC_W;

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_ones;
   logic              frac_nz;

   assign exp_f    = op[W-2 -: EXP_W];
   assign frac_f   = op[FRAC_W-1:0];
   assign exp_ones = &exp_f;
   assign frac_nz  = |frac_f;

   always_comb begin
      cls.sign    = op[W-1];
      cls.is_nan  = exp_ones && frac_nz;
      // fraction MSB clear marks a signaling NaN
      cls.is_snan = exp_ones && frac_nz && !frac_f[FRAC_W-1];
      cls.is_zero = (exp_f == '0) && !frac_nz;
   end
endmodule

// File: rtl/fmax_quiet_cmp.sv
module fmax_quiet_cmp
   import fmax_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] x,
   input  logic [EXP_W+FRAC_W:0] y,
   input  fp_class_t             cls_x,
   input  fp_class_t             cls_y,
   output logic                  x_lt_y,
   output logic                  x_eq_y
);
   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int MAG_W = W - 1;

   logic [MAG_W-1:0] mag_x, mag_y;
   logic             any_nan, both_zero, lt_raw, eq_raw;

   assign mag_x     = x[MAG_W-1:0];
   assign mag_y     = y[MAG_W-1:0];
   assign any_nan   = cls_x.is_nan || cls_y.is_nan;
   assign both_zero = cls_x.is_zero && cls_y.is_zero;

   always_comb begin
      if (both_zero)
         lt_raw = 1'b0;
      else if (cls_x.sign != cls_y.sign)
         lt_raw = cls_x.sign;
      else if (!cls_x.sign)
         lt_raw = mag_x < mag_y;
      else
         lt_raw = mag_x > mag_y;
      eq_raw = both_zero || (x == y);
   end

   // unordered operands compare neither less nor equal
   assign x_lt_y = lt_raw && !any_nan;
   assign x_eq_y = eq_raw && !any_nan;
endmodule

// File: rtl/fmax_select.sv
module fmax_select
   import fmax_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] src1,
   input  logic [EXP_W+FRAC_W:0] src2,
   input  fp_class_t             cls1,
   input  fp_class_t             cls2,
   input  logic                  src2_lt_src1,
   input  logic                  src2_eq_src1,
   output logic [EXP_W+FRAC_W:0] res,
   output logic                  invalid
);
   localparam int W = 1 + EXP_W + FRAC_W;
   localparam logic [W-1:0] CANON_NAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic take_src1;

   // equal with negative second source: first source wins (+0 over -0)
   assign take_src1 = src2_lt_src1 || (src2_eq_src1 && cls2.sign);

   always_comb begin
      if (cls1.is_nan && cls2.is_nan)
         res = CANON_NAN;
      else if (cls2.is_nan)
         res = src1;
      else if (cls1.is_nan)
         res = src2;
      else if (take_src1)
         res = src1;
      else
         res = src2;
      invalid = cls1.is_snan || cls2.is_snan;
   end
endmodule

// File: rtl/fmax_d_unit.sv
module fmax_d_unit
   import fmax_pkg::*;
#(
   parameter int EXP_W      = 11,
   parameter int FRAC_W     = 52,
   parameter bit REGISTERED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  use_int_src,
   input  logic [EXP_W+FRAC_W:0] fp_src1,
   input  logic [EXP_W+FRAC_W:0] fp_src2,
   input  logic [EXP_W+FRAC_W:0] int_src1,
   input  logic [EXP_W+FRAC_W:0] int_src2,
   output logic [EXP_W+FRAC_W:0] max_out,
   output logic                  invalid_out
);
   localparam int W = 1 + EXP_W + FRAC_W;
   localparam logic [W-1:0] CANON_NAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   initial begin
      assert (EXP_W >= 2) else $error("EXP_W must be at least 2");
      assert (FRAC_W >= 2) else $error("FRAC_W must be at least 2");
   end

   logic [W-1:0] ops [2];
   fp_class_t    cls [2];
   logic         s2_lt_s1, s2_eq_s1;
   logic [W-1:0] res_c;
   logic         inv_c;

   // register-source selection
   assign ops[0] = use_int_src ? int_src1 : fp_src1;
   assign ops[1] = use_int_src ? int_src2 : fp_src2;

   for (genvar g = 0; g < 2; g++) begin : g_cls
      fmax_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .op  (ops[g]),
         .cls (cls[g])
      );
   end

   fmax_quiet_cmp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cmp (
      .x      (ops[1]),
      .y      (ops[0]),
      .cls_x  (cls[1]),
      .cls_y  (cls[0]),
      .x_lt_y (s2_lt_s1),
      .x_eq_y (s2_eq_s1)
   );

   fmax_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
      .src1         (ops[0]),
      .src2         (ops[1]),
      .cls1         (cls[0]),
      .cls2         (cls[1]),
      .src2_lt_src1 (s2_lt_s1),
      .src2_eq_src1 (s2_eq_s1),
      .res          (res_c),
      .invalid      (inv_c)
   );

   if (REGISTERED) begin : g_reg
      logic [W-1:0] res_q;
      logic         inv_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_q <= '0;
            inv_q <= 1'b0;
         end else begin
            res_q <= res_c;
            inv_q <= inv_c;
         end
      end

      assign max_out     = res_q;
      assign invalid_out = inv_q;

      assert_two_nan_canon_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (cls[0].is_nan && cls[1].is_nan) |=> (max_out == CANON_NAN));

      assert_snan_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (cls[0].is_snan || cls[1].is_snan) |=> invalid_out);

      assert_no_snan_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !(cls[0].is_snan || cls[1].is_snan) |=> !invalid_out);

      assert_one_nan_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (cls[0].is_nan && !cls[1].is_nan) |=> (max_out == $past(ops[1])));

      assert_zero_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (cls[0].is_zero && cls[1].is_zero && (cls[0].sign != cls[1].sign))
         |=> (max_out == '0));
   end else begin : g_comb
      assign max_out     = res_c;
      assign invalid_out = inv_c;
   end
endmodule

// File: tb/fmax_d_unit_tb.sv
`timescale 1ns/1ps
module fmax_d_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        use_int_src = 1'b0;
   logic [63:0] fp_src1 = '0, fp_src2 = '0, int_src1 = '0, int_src2 = '0;
   logic [63:0] max_out;
   logic        invalid_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   fmax_d_unit u_dut (
      .clk(clk), .rst_n(rst_n), .use_int_src(use_int_src),
      .fp_src1(fp_src1), .fp_src2(fp_src2),
      .int_src1(int_src1), .int_src2(int_src2),
      .max_out(max_out), .invalid_out(invalid_out)
   );

   localparam logic [63:0] CANON = 64'h7FF8_0000_0000_0000;

   function automatic bit is_nan(input logic [63:0] v);
      return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
   endfunction

   function automatic bit is_snan(input logic [63:0] v);
      return is_nan(v) && !v[51];
   endfunction

   // behavioural reference using the simulator's own real arithmetic
   function automatic logic [63:0] ref_max(input logic [63:0] a, input logic [63:0] b);
      real ra, rb;
      if (is_nan(a) && is_nan(b)) return CANON;
      if (is_nan(b)) return a;
      if (is_nan(a)) return b;
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      if (rb < ra) return a;
      if (ra < rb) return b;
      if (b[63]) return a;
      return b;
   endfunction

   task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: result actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check1(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: flag actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // drive one operand pair on the selected source, garbage on the other
   task automatic run(input logic [63:0] a, input logic [63:0] b, input logic m,
                      input string tag);
      @(negedge clk);
      use_int_src = m;
      if (m) begin
         int_src1 = a; int_src2 = b;
         fp_src1 = ~a; fp_src2 = 64'h7FF0_0000_0000_0001;
      end else begin
         fp_src1 = a; fp_src2 = b;
         int_src1 = 64'hFFF0_0000_0000_0003; int_src2 = ~b;
      end
      @(posedge clk);
      #1;
      check64(tag, max_out, ref_max(a, b));
      check1(tag, invalid_out, is_snan(a) || is_snan(b));
   endtask

   logic [63:0] pool [14];

   initial begin
      pool[0]  = 64'h0000_0000_0000_0000; pool[1]  = 64'h8000_0000_0000_0000;
      pool[2]  = 64'h7FF0_0000_0000_0000; pool[3]  = 64'hFFF0_0000_0000_0000;
      pool[4]  = 64'h7FF8_0000_0000_0000; pool[5]  = 64'hFFF8_0000_0000_0001;
      pool[6]  = 64'h7FF0_0000_0000_0001; pool[7]  = 64'hFFF4_0000_0000_0000;
      pool[8]  = 64'h0000_0000_0000_0001; pool[9]  = 64'h8000_0000_0000_0001;
      pool[10] = 64'h000F_FFFF_FFFF_FFFF; pool[11] = 64'h3FF0_0000_0000_0000;
      pool[12] = 64'hBFF0_0000_0000_0000; pool[13] = 64'h7FEF_FFFF_FFFF_FFFF;

      // R8: reset clears outputs
      fp_src1 = 64'h7FF0_0000_0000_0001; fp_src2 = 64'h3FF0_0000_0000_0000;
      repeat (3) @(posedge clk);
      #1;
      check64("R8 reset", max_out, 64'd0);
      check1("R8 reset", invalid_out, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      run(64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 0, "R1 2.0 vs 1.0");
      run(64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF, 0, "R1 +inf vs max");
      run(64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 1, "R1 negatives");
      run(64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001, 0, "R1 subnormals");
      run(64'hFFF0_0000_0000_0000, 64'h8000_0000_0000_0001, 0, "R2 -inf vs -sub");
      run(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 1, "R2 sign order");
      run(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 0, "R3 -0,+0");
      run(64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, "R3 +0,-0");
      run(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 1, "R3 -0,+0 int");
      run(64'hC008_0000_0000_0000, 64'hC008_0000_0000_0000, 0, "R3 identical");
      run(64'h7FF8_0000_0000_0000, 64'hFFF8_0000_0000_0001, 0, "R4 two qNaN");
      run(64'h7FF0_0000_0000_0001, 64'h7FF4_0000_0000_0000, 1, "R4 two sNaN");
      run(64'h7FF8_0000_0000_0000, 64'hBFF0_0000_0000_0000, 0, "R5 qNaN first");
      run(64'h8000_0000_0000_0000, 64'hFFF8_0000_0000_0001, 0, "R5 qNaN second");
      run(64'h7FF0_0000_0000_0001, 64'hFFF0_0000_0000_0000, 0, "R6 sNaN first");
      run(64'h3FF0_0000_0000_0000, 64'hFFF4_0000_0000_0000, 1, "R6 sNaN second");
      run(64'h7FF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, 1, "R6 qNaN no flag");
      run(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1, "R7 int source");
      run(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 0, "R7 fp source");

      // all special pairs in both modes
      for (int i = 0; i < 14; i++)
         for (int j = 0; j < 14; j++)
            run(pool[i], pool[j], 1'((i + j) % 2), "R1 R2 R5 special pair");

      // random operands, sometimes with a special value mixed in
      for (int k = 0; k < 400; k++) begin
         logic [63:0] a, b;
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         if (k % 4 == 1) b = pool[$urandom % 14];
         if (k % 4 == 2) a = pool[$urandom % 14];
         if (k % 8 == 3) b = {a[63:1], ~a[0]};
         run(a, b, 1'(k % 2), "R1 R2 R7 random");
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule